// File: doc/BRIEF.md
# Indexed Indirect Effective-Address Unit

This unit turns an instruction held in main memory into its final operand address. Given a program counter value and a start pulse, it reads the 36-bit instruction word over a request/acknowledge memory port and keeps the 6-bit opcode. If the instruction names an index location, it reads that memory word and adds its low 15 bits to the base address. The adder is a 15-bit ring adder, so any carry out of the top bit wraps back into bit 0. If the indirect flag is set, the unit reads the word at the resulting address and handles that word in the same way. This repeats until a word arrives with the indirect flag clear.

When the sequence ends, the unit presents the final address, the opcode and the adder register, and pulses `done` for one cycle. For the jump-and-save opcode, the adder register instead holds the program counter the instruction was fetched from. A parameter caps the number of indirect reads. If a chain reaches the cap, the unit stops and raises an error flag.

Top module: `ea_unit`

## Requirements
- R1: After reset, `mem_req`, `done` and `err` are 0 and `ea` is 0.
- R2: A `start` pulse in idle makes the unit request address `pc_in` on the next cycle. The opcode reported is bits [35:30] of the word returned.
- R3: For a word whose index selector (bits [28:20]) is 0 and whose indirect flag (bit 29) is 0, `ea` and `adder_q` equal bits [14:0] of that word. Exactly one memory read is made. `done` is a one-cycle pulse and `mem_req` is low while `done` is high.
- R4: A nonzero index selector x causes one read of location x. Then `ea` = `adder_q` = base address + bits [14:0] of that word.
- R5: The index addition wraps a carry out of bit 14 into bit 0. For example, 0x7FFF + 0x0002 gives 0x0002, and 0x7FFF + 0x7FFF gives 0x7FFF.
- R6: When the indirect flag is set, the unit reads the word at the current (already indexed) address and treats it like a new instruction word for indexing and indirection. It stops at the first word whose indirect flag is clear.
- R7: With MAX_IND = 4 (the default), a chain of exactly 4 indirect reads ends normally with `err` = 0. If the 4th indirect word still has its flag set, the unit ends with `err` = 1 and `ea` = that word's (indexed) address. `err` is cleared by the next `start`.
- R8: When the opcode equals JS_OP (default 31), `adder_q` holds the fetch address `pc_in` at `done`. `ea` is still computed normally.
- R9: The unit holds `mem_req` and keeps `mem_addr` steady until `mem_ack` arrives, for any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address resolution (taken only in idle) |
| pc_in | input | 15 | Address of the instruction to resolve |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 15 | Memory read address |
| mem_ack | input | 1 | One-cycle read acknowledge, data valid with it |
| mem_rdata | input | 36 | Read data |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 15 | Final effective address |
| opcode | output | 6 | Opcode of the fetched instruction |
| adder_q | output | 15 | Index adder register (saved PC on jump-and-save) |
| err | output | 1 | Indirect chain hit the step limit |

## Verification
If the state register or the step counter goes wrong, the sequence of read addresses changes at once. The number of reads between `start` and `done` also changes, and the bench counts these reads. A fault in the ring adder shows only in `ea` and `adder_q` at the `done` pulse, and only when a carry leaves bit 14. For this reason the bench uses operands that force that carry. A wrong opcode latch shows at `done` as a wrong `opcode`, or as a jump-and-save `adder_q` that does not equal the fetch address.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int AW      = 15,
  parameter int DW      = 36,
  parameter int XW      = 9,
  parameter int OPW     = 6,
  parameter int MAX_IND = 4,
  parameter logic [5:0] JS_OP = 6'd31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] pc_in,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [OPW-1:0] opcode,
  output logic [AW-1:0] adder_q,
  output logic          err
);
  localparam int OP_LSB = DW - OPW;
  localparam int IND_B  = OP_LSB - 1;
  localparam int X_LSB  = IND_B - XW;
  localparam int CW     = $clog2(MAX_IND + 1);
  localparam logic [CW-1:0] LIM = CW'(MAX_IND);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_IDX, S_IND} st_t;
  st_t state;

  logic [AW-1:0] mar, pc_q, y_q;
  logic          ind_q;
  logic [CW-1:0] ind_cnt;

  wire [OPW-1:0] w_op  = mem_rdata[DW-1:OP_LSB];
  wire           w_ind = mem_rdata[IND_B];
  wire [XW-1:0]  w_x   = mem_rdata[IND_B-1:X_LSB];
  wire [AW-1:0]  w_y   = mem_rdata[AW-1:0];
  logic unused_bits;
  assign unused_bits = ^mem_rdata[X_LSB-1:AW];

  wire [AW:0]   raw  = {1'b0, y_q} + {1'b0, w_y};
  wire [AW-1:0] ring = raw[AW-1:0] + {{(AW-1){1'b0}}, raw[AW]};

  logic          go_idx, res_ind;
  logic [AW-1:0] res_addr;
  wire [OPW-1:0] op_now = (state == S_FETCH) ? w_op : opcode;

  always_comb begin
    go_idx   = 1'b0;
    res_addr = ring;
    res_ind  = ind_q;
    if (state != S_IDX) begin
      go_idx   = (w_x != '0);
      res_addr = w_y;
      res_ind  = w_ind;
    end
  end

  assign mem_req  = (state != S_IDLE);
  assign mem_addr = mar;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; mar <= '0; pc_q <= '0; y_q <= '0; ind_q <= 1'b0;
      ind_cnt <= '0; done <= 1'b0; ea <= '0; opcode <= '0; adder_q <= '0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          state <= S_FETCH; mar <= pc_in; pc_q <= pc_in;
          ind_cnt <= '0; err <= 1'b0;
        end
      end else if (mem_ack) begin
        if (state == S_FETCH) opcode <= w_op;
        adder_q <= res_addr;
        if (go_idx) begin
          state <= S_IDX; mar <= {{(AW-XW){1'b0}}, w_x};
          y_q <= w_y; ind_q <= w_ind;
        end else if (res_ind && ind_cnt != LIM) begin
          state <= S_IND; mar <= res_addr; ind_cnt <= ind_cnt + CW'(1);
        end else begin
          state <= S_IDLE; done <= 1'b1; ea <= res_addr; err <= res_ind;
          if (op_now == JS_OP) adder_q <= pc_q;
        end
      end
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> (mem_req && mem_addr == $past(pc_in)));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
  assert_err_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

// File: tb/ea_unit_tb_top.sv
`timescale 1ns/1ps
module ea_unit_tb_top;
  logic clk = 0, rst_n = 0, start = 0, mem_ack = 0;
  logic [14:0] pc_in = '0;
  logic [35:0] mem_rdata = '0;
  logic mem_req, done, err;
  logic [14:0] mem_addr, ea, adder_q;
  logic [5:0] opcode;
  int errors = 0, checks = 0, lat = 0, cnt = 0, reads = 0, elapsed = 0;
  logic [35:0] mem [int];

  always #2.5 clk = ~clk;

  ea_unit dut_i (.clk, .rst_n, .start, .pc_in, .mem_req, .mem_addr, .mem_ack,
                 .mem_rdata, .done, .ea, .opcode, .adder_q, .err);

  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack <= 1'b1; cnt <= 0; reads <= reads + 1;
        mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 36'd0;
      end else cnt <= cnt + 1;
    end
  end

  function automatic logic [35:0] w(input logic [5:0] op, input logic ind,
                                    input logic [8:0] x, input logic [14:0] y);
    return {op, ind, x, 5'd0, y};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic run(input logic [14:0] pc, output int nreads);
    int r0;
    r0 = reads;
    @(negedge clk); pc_in = pc; start = 1;
    @(negedge clk); start = 0;
    elapsed = 1;
    for (int i = 0; i < 3000; i++) begin
      if (done) break;
      @(negedge clk); elapsed++;
    end
    nreads = reads - r0;
  endtask

  task automatic t_reset();
    chk(mem_req == 0, "R1 mem_req", mem_req, 0);
    chk(done == 0 && err == 0, "R1 done/err", {done, err}, 0);
    chk(ea == 0, "R1 ea", ea, 0);
  endtask

  task automatic t_direct();
    int n;
    lat = 0; mem[100] = w(6'd5, 0, 0, 15'h1234);
    run(15'd100, n);
    chk(opcode == 5, "R2 opcode", opcode, 5);
    chk(ea == 15'h1234 && adder_q == 15'h1234, "R3 ea", ea, 'h1234);
    chk(n == 1, "R3 read count", n, 1);
    @(negedge clk);
    chk(done == 0, "R3 done pulse width", done, 0);
  endtask

  task automatic t_index();
    int n;
    lat = 3; mem[200] = w(6'd7, 0, 9'd3, 15'h0100); mem[3] = 36'h0020;
    run(15'd200, n);
    chk(ea == 15'h0120 && adder_q == 15'h0120, "R4 indexed ea", ea, 'h120);
    chk(n == 2, "R4 read count", n, 2);
  endtask

  task automatic t_ring();
    int n;
    lat = 1; mem[210] = w(6'd1, 0, 9'd5, 15'h7FFF); mem[5] = 36'h0002;
    run(15'd210, n);
    chk(ea == 15'h0002, "R5 end-around carry", ea, 2);
    mem[220] = w(6'd1, 0, 9'd6, 15'h7FFF); mem[6] = 36'h7FFF;
    run(15'd220, n);
    chk(ea == 15'h7FFF, "R5 max plus max", ea, 'h7FFF);
  endtask

  task automatic t_chain();
    int n;
    lat = 0;
    mem[300] = w(6'd2, 1, 0, 15'h0400);
    mem['h400] = w(6'd0, 1, 9'd4, 15'h0500); mem[4] = 36'h0010;
    mem['h510] = w(6'd0, 0, 0, 15'h0777);
    run(15'd300, n);
    chk(ea == 15'h0777 && opcode == 2, "R6 chain ea", ea, 'h777);
    chk(n == 4 && err == 0, "R6 chain reads", n, 4);
  endtask

  task automatic t_limit();
    int n;
    lat = 0;
    mem[400] = w(6'd3, 1, 0, 15'h0600);
    for (int k = 0; k < 10; k++) mem['h600 + k] = w(6'd0, 1, 0, 15'h0601 + 15'(k));
    run(15'd400, n);
    chk(err == 1, "R7 limit err", err, 1);
    chk(ea == 15'h0604 && n == 5, "R7 limit ea", ea, 'h604);
    mem[410] = w(6'd3, 1, 0, 15'h0700);
    mem['h700] = w(0, 1, 0, 15'h0701); mem['h701] = w(0, 1, 0, 15'h0702);
    mem['h702] = w(0, 1, 0, 15'h0703); mem['h703] = w(0, 0, 0, 15'h0ABC);
    run(15'd410, n);
    chk(err == 0 && ea == 15'h0ABC, "R7 exact limit ok", ea, 'hABC);
  endtask

  task automatic t_js();
    int n;
    lat = 0; mem[500] = w(6'd31, 0, 9'd2, 15'h0050); mem[2] = 36'h0001;
    run(15'd500, n);
    chk(adder_q == 15'd500, "R8 saved pc", adder_q, 500);
    chk(ea == 15'h0051, "R8 ea", ea, 'h51);
  endtask

  task automatic t_wait();
    int n;
    lat = 7; mem[600] = w(6'd9, 0, 9'd7, 15'h0003); mem[7] = 36'h0004;
    run(15'd600, n);
    chk(ea == 15'h0007 && n == 2, "R9 slow memory ea", ea, 7);
    chk(elapsed >= 16, "R9 waited for ack", elapsed, 16);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_direct(); t_index(); t_ring(); t_chain(); t_limit(); t_js(); t_wait();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule